// File: doc/BRIEF.md
# Serial Management Slave with Indirect Register Pointer

This block is the management-plane endpoint of a layered transceiver device. It listens on a two-wire serial management bus, with a clock driven by the station manager and one shared data line. It recognises frames addressed to its strapped port and device identifiers and serves a small bank of 16-bit registers. Registers are not addressed inside the data frame. A separate address frame loads a 16-bit pointer, and later write, read and read-then-increment frames act on the register that pointer selects.

The slave keeps frame alignment strictly. A frame is only considered after an unbroken run of ones, and a bad start code throws the slave back to hunting for a fresh run of ones. Register 0 carries a self-clearing reset bit. Setting it returns the pointer and every register to its default and holds the bank busy for a fixed number of clocks, during which all modifying frames are discarded. Register 1 reports whether the transmit lanes are de-skewed, through a latched-low bit. The de-skew detection itself lies outside and arrives as an input level.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is accepted only if at least PRE_LEN (default 32) consecutive ones were sampled immediately before its first start bit; a frame preceded by fewer ones (for example 31) has no effect and gets no response.
- R2: After the first start bit (0), a second start bit other than 1 (start code 00) drops the frame with no effect; the slave then needs a new full run of ones before it accepts another frame.
- R3: A frame whose 5-bit port field (frame bits 4..8, MSB first) or 5-bit device field (bits 9..13) differs from the strapped port_id or dev_id changes no state and never drives the data line.
- R4: Opcode field (frame bits 2..3): 00 loads the 16-bit data field into the pointer, 01 writes the data field to the register at the pointer, and 11 returns the register at the pointer.
- R5: On a read, mdio_oe stays low during the first turnaround bit period, the slave drives 0 in the second turnaround period, then drives the 16 register bits MSB first, one per clock period, and lowers mdio_oe after the last one.
- R6: Opcode 10 returns the register at the pointer exactly as opcode 11 does, and afterwards the pointer is one higher.
- R7: When opcode 10 is issued with the pointer at 0xFFFF, the pointer stays at 0xFFFF instead of wrapping to 0.
- R8: Register map: address 0 holds the reset bit (bit 15) and 15 writable bits (14..0, default 0); address 1 is read-only; addresses 2 to NUM_REGS-1 are writable with default 0xA000 plus the address; addresses at or above NUM_REGS read as 0 and ignore writes.
- R9: Writing a 1 into bit 15 of address 0 clears the pointer and every register to its default; bit 15 of address 0 reads as 1 for RST_CYCLES clocks afterwards and then reads 0.
- R10: While the reset of R9 or R12 is in progress, write, pointer-load and pointer-increment frames are discarded.
- R11: Bit 4 of address 1 (all other bits 0) shows the de-skew input latched low: after the input goes low the bit reads 0 until one read of address 1 has returned it, and it then follows the input again.
- R12: While rst_n is low mdio_oe is low; after rst_n rises all registers hold their defaults, the pointer is 0, and the reset period of R9 runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all sampling and driving on its rising edge |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| mdio_in | input | 1 | Resolved level of the shared data line |
| mdio_out | output | 1 | Level driven onto the data line when enabled |
| mdio_oe | output | 1 | Data line drive enable (high = slave drives) |
| port_id | input | 5 | Strapped port identifier |
| dev_id | input | 5 | Strapped device identifier |
| deskew_ok | input | 1 | Live indication that the transmit lanes are de-skewed |

## Verification
The slave samples each frame bit on the rising edge that closes that bit's period. Its drive enable and data therefore change on that same edge and apply to the following period. The bench compares drive enable and level at every falling edge against a behavioural model, so the turnaround release, the leading 0 and each data bit are checked in the exact period they belong to. Register, pointer and reset effects take hold on the edge that samples the last data bit. The model applies them just after that edge and judges busy status by counting clocks from the edge that started the reset, so the busy window is only probed well inside or well outside its RST_CYCLES span.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;

   typedef enum logic [1:0] {
      OP_LOAD_PTR = 2'b00,
      OP_WRITE    = 2'b01,
      OP_READ_INC = 2'b10,
      OP_READ     = 2'b11
   } mdio_op_e;

   localparam int DATA_W    = 16;
   localparam int ID_W      = 5;
   localparam int BIT_IDX_W = 5;

   function automatic logic [DATA_W-1:0] reg_default(input int idx);
      if (idx < 2) return '0;
      return 16'hA000 | DATA_W'(idx);
   endfunction

endpackage

// File: rtl/mdio_frame_rx.sv
module mdio_frame_rx
   import mdio_slv_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mdio_in,
   input  logic [ID_W-1:0]   port_id,
   input  logic [ID_W-1:0]   dev_id,
   input  logic [DATA_W-1:0] rd_data,
   output logic              mdio_out,
   output logic              mdio_oe,
   output logic              rd_cap,
   output logic              end_stb,
   output mdio_op_e          end_op,
   output logic [DATA_W-1:0] end_data
);

   localparam int PCW = $clog2(PRE_LEN + 1);
   localparam logic [PCW-1:0] PRE_MAX = PCW'(PRE_LEN);
   localparam logic [BIT_IDX_W-1:0] IDX_ST2  = 5'd1;
   localparam logic [BIT_IDX_W-1:0] IDX_HDR  = 5'd13;
   localparam logic [BIT_IDX_W-1:0] IDX_TA1  = 5'd14;
   localparam logic [BIT_IDX_W-1:0] IDX_D0   = 5'd15;
   localparam logic [BIT_IDX_W-1:0] IDX_DL   = 5'd30;
   localparam logic [BIT_IDX_W-1:0] IDX_LAST = 5'd31;

   generate
      if (PRE_LEN < 1) begin : g_bad_pre
         $error("PRE_LEN must be at least 1");
      end
   endgenerate

   logic                 in_frame;
   logic [PCW-1:0]       pre_cnt;
   logic [BIT_IDX_W-1:0] idx;
   logic [DATA_W-2:0]    sr;
   logic [DATA_W-1:0]    tx_sr;
   mdio_op_e             op_q;
   logic                 oe_q;
   logic                 out_q;

   logic          hdr_done;
   logic          hdr_match;
   mdio_op_e      hdr_op;
   logic [ID_W-1:0] rx_port;
   logic [ID_W-1:0] rx_dev;

   assign hdr_done  = in_frame && (idx == IDX_HDR);
   assign rx_port   = sr[8:4];
   assign rx_dev    = {sr[3:0], mdio_in};
   assign hdr_op    = mdio_op_e'(sr[10:9]);
   assign hdr_match = (rx_port == port_id) && (rx_dev == dev_id);

   assign rd_cap   = in_frame && (idx == IDX_TA1) && op_q[1];
   assign end_stb  = in_frame && (idx == IDX_LAST);
   assign end_op   = op_q;
   assign end_data = {sr, mdio_in};

   assign mdio_oe  = oe_q;
   assign mdio_out = out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame <= 1'b0;
         pre_cnt  <= '0;
         idx      <= '0;
         sr       <= '0;
         tx_sr    <= '0;
         op_q     <= OP_LOAD_PTR;
         oe_q     <= 1'b0;
         out_q    <= 1'b0;
      end else if (!in_frame) begin
         if (mdio_in) begin
            if (pre_cnt != PRE_MAX) pre_cnt <= pre_cnt + PCW'(1);
         end else if (pre_cnt == PRE_MAX) begin
            in_frame <= 1'b1;
            idx      <= IDX_ST2;
            sr       <= '0;
         end else begin
            pre_cnt <= '0;
         end
      end else begin
         sr  <= {sr[DATA_W-3:0], mdio_in};
         idx <= idx + 5'd1;
         if (idx == IDX_ST2 && !mdio_in) begin
            in_frame <= 1'b0;
            pre_cnt  <= '0;
         end
         if (hdr_done) begin
            op_q <= hdr_op;
            if (!hdr_match) begin
               in_frame <= 1'b0;
               pre_cnt  <= '0;
            end
         end
         if (rd_cap) begin
            oe_q  <= 1'b1;
            out_q <= 1'b0;
            tx_sr <= rd_data;
         end
         if (oe_q && idx >= IDX_D0 && idx <= IDX_DL) begin
            out_q <= tx_sr[DATA_W-1];
            tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
         end
         if (end_stb) begin
            in_frame <= 1'b0;
            pre_cnt  <= '0;
            oe_q     <= 1'b0;
         end
      end
   end

   assert_ta_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_frame && idx == IDX_TA1) |-> !mdio_oe);

   assert_drive_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_oe |-> in_frame);

   assert_bad_start_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_frame && idx == IDX_ST2 && !mdio_in) |=> (!in_frame && !mdio_oe));

   assert_id_mismatch_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_done && !hdr_match) |=> (!in_frame && !mdio_oe));

endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
   import mdio_slv_pkg::*;
#(
   parameter int NUM_REGS   = 8,
   parameter int RST_CYCLES = 200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              deskew_ok,
   input  logic              rd_cap,
   input  logic              end_stb,
   input  mdio_op_e          end_op,
   input  logic [DATA_W-1:0] end_data,
   output logic [DATA_W-1:0] rd_data
);

   localparam int CW = $clog2(RST_CYCLES + 1);
   localparam int AW = (NUM_REGS > 2) ? $clog2(NUM_REGS) : 1;
   localparam logic [CW-1:0] RST_LOAD = CW'(RST_CYCLES);
   localparam logic [DATA_W:0] NREG_W = (DATA_W+1)'(NUM_REGS);
   localparam logic [DATA_W-1:0] PTR_MAX = '1;
   localparam int DESKEW_BIT = 4;

   generate
      if (NUM_REGS < 2 || NUM_REGS > 1024) begin : g_bad_nregs
         $error("NUM_REGS must lie in 2..1024");
      end
      if (RST_CYCLES < 1) begin : g_bad_rst
         $error("RST_CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0]        busy_cnt;
   logic                 busy;
   logic [DATA_W-1:0]    ptr;
   logic [DATA_W-2:0]    ctrl_q;
   logic                 lat_q;
   logic [DATA_W-1:0]    rd_vec [NUM_REGS];

   logic wr_go, load_go, inc_go, soft_go, clr;

   assign busy    = (busy_cnt != '0);
   assign wr_go   = end_stb && !busy && (end_op == OP_WRITE);
   assign load_go = end_stb && !busy && (end_op == OP_LOAD_PTR);
   assign inc_go  = end_stb && !busy && (end_op == OP_READ_INC);
   assign soft_go = wr_go && (ptr == '0) && end_data[DATA_W-1];
   assign clr     = busy || soft_go;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       busy_cnt <= RST_LOAD;
      else if (soft_go) busy_cnt <= RST_LOAD;
      else if (busy)    busy_cnt <= busy_cnt - CW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ptr <= '0;
      else if (clr)                        ptr <= '0;
      else if (load_go)                    ptr <= end_data;
      else if (inc_go && ptr != PTR_MAX)   ptr <= ptr + DATA_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     ctrl_q <= '0;
      else if (clr)                   ctrl_q <= '0;
      else if (wr_go && ptr == '0)    ctrl_q <= end_data[DATA_W-2:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     lat_q <= 1'b1;
      else if (clr)                   lat_q <= 1'b1;
      else if (rd_cap && ptr == DATA_W'(1)) lat_q <= deskew_ok;
      else                            lat_q <= lat_q & deskew_ok;
   end

   assign rd_vec[0] = {busy, ctrl_q};
   assign rd_vec[1] = DATA_W'({lat_q, DESKEW_BIT'(0)});

   for (genvar gi = 2; gi < NUM_REGS; gi++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              q <= reg_default(gi);
         else if (clr)                            q <= reg_default(gi);
         else if (wr_go && ptr == DATA_W'(gi))    q <= end_data;
      end
      assign rd_vec[gi] = q;
   end

   assign rd_data = ({1'b0, ptr} < NREG_W) ? rd_vec[ptr[AW-1:0]] : '0;

   assert_ptr_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr == PTR_MAX && end_stb && end_op == OP_READ_INC) |=> (ptr == PTR_MAX));

   assert_busy_discard_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && end_stb) |=> (ptr == '0 && ctrl_q == '0));

   assert_latch_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!deskew_ok && !busy) |=> !lat_q);

   assert_reset_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      soft_go |=> rd_vec[0][DATA_W-1]);

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
   import mdio_slv_pkg::*;
#(
   parameter int NUM_REGS   = 8,
   parameter int RST_CYCLES = 200,
   parameter int PRE_LEN    = 32
) (
   input  logic       mdc,
   input  logic       rst_n,
   input  logic       mdio_in,
   output logic       mdio_out,
   output logic       mdio_oe,
   input  logic [4:0] port_id,
   input  logic [4:0] dev_id,
   input  logic       deskew_ok
);

   logic              rd_cap;
   logic              end_stb;
   mdio_op_e          end_op;
   logic [DATA_W-1:0] end_data;
   logic [DATA_W-1:0] rd_data;

   mdio_frame_rx #(.PRE_LEN(PRE_LEN)) u_rx (
      .clk      (mdc),
      .rst_n    (rst_n),
      .mdio_in  (mdio_in),
      .port_id  (port_id),
      .dev_id   (dev_id),
      .rd_data  (rd_data),
      .mdio_out (mdio_out),
      .mdio_oe  (mdio_oe),
      .rd_cap   (rd_cap),
      .end_stb  (end_stb),
      .end_op   (end_op),
      .end_data (end_data)
   );

   mdio_reg_bank #(.NUM_REGS(NUM_REGS), .RST_CYCLES(RST_CYCLES)) u_bank (
      .clk       (mdc),
      .rst_n     (rst_n),
      .deskew_ok (deskew_ok),
      .rd_cap    (rd_cap),
      .end_stb   (end_stb),
      .end_op    (end_op),
      .end_data  (end_data),
      .rd_data   (rd_data)
   );

   assert_reset_release_R12: assert property (@(posedge mdc) disable iff (!rst_n)
      $rose(rst_n) |-> !mdio_oe);

endmodule

// File: tb/mdio_mgmt_slave_tb.sv
module mdio_mgmt_slave_tb;

   localparam int NREG = 8;
   localparam int RSTC = 200;
   localparam logic [4:0] PORT = 5'h0A;
   localparam logic [4:0] DEV  = 5'h03;

   logic mdc = 1'b0;
   logic rst_n = 1'b0;
   logic mst_drv = 1'b1;
   logic deskew = 1'b1;
   logic dut_out, dut_oe;
   wire  mdio_line = dut_oe ? dut_out : mst_drv;

   always #2 mdc = ~mdc;

   mdio_mgmt_slave #(.NUM_REGS(NREG), .RST_CYCLES(RSTC), .PRE_LEN(32)) u_dut (
      .mdc(mdc), .rst_n(rst_n), .mdio_in(mdio_line),
      .mdio_out(dut_out), .mdio_oe(dut_oe),
      .port_id(PORT), .dev_id(DEV), .deskew_ok(deskew)
   );

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   always @(posedge mdc) cyc <= cyc + 1;

   logic [15:0] m_reg [NREG];
   logic [15:0] m_ptr;
   int          busy_until;
   logic        m_lat;

   task automatic m_defaults();
      m_reg[0] = 16'h0;
      m_reg[1] = 16'h0;
      for (int i = 2; i < NREG; i++) m_reg[i] = 16'hA000 | 16'(i);
      m_ptr = 16'h0;
   endtask

   function automatic logic [15:0] m_read(input bit b);
      if (m_ptr == 16'd0) return {b, m_reg[0][14:0]};
      if (m_ptr == 16'd1) return b ? 16'h0010 : {11'b0, m_lat, 4'b0};
      if (m_ptr < 16'(NREG)) return m_reg[m_ptr];
      return 16'h0;
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick_cmp(input bit eo, input bit ev, input string tag);
      @(negedge mdc);
      checks++;
      if (dut_oe !== eo || (eo && dut_out !== ev)) begin
         errors++;
         $display("FAIL %s cycle %0d: actual oe=%b out=%b expected oe=%b out=%b",
                  tag, cyc, dut_oe, dut_out, eo, ev);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         tick_cmp(1'b0, 1'b0, "R5 idle");
         mst_drv = 1'b1;
      end
   endtask

   task automatic frame(input logic [1:0] st, input logic [1:0] op,
                        input logic [4:0] prt, input logic [4:0] dv,
                        input logic [15:0] data, input int pre, input bit accept,
                        input string tag, output logic [15:0] got);
      logic [31:0] bits;
      logic [15:0] exp_rd;
      bit resp;
      bit bz;
      bits   = {st, op, prt, dv, 2'b10, data};
      resp   = accept && op[1];
      exp_rd = 16'h0;
      got    = 16'h0;
      repeat (pre) begin
         tick_cmp(1'b0, 1'b0, tag);
         mst_drv = 1'b1;
      end
      for (int k = 0; k < 32; k++) begin
         if (resp && k == 15) begin
            bz = (cyc <= busy_until);
            exp_rd = m_read(bz);
            if (!bz && m_ptr == 16'd1) m_lat = deskew;
         end
         if (resp && k >= 15) tick_cmp(1'b1, (k == 15) ? 1'b0 : exp_rd[31-k], tag);
         else                 tick_cmp(1'b0, 1'b0, tag);
         if (resp && k >= 16) got[31-k] = mdio_line;
         mst_drv = (resp && k >= 14) ? 1'b1 : bits[31-k];
      end
      @(posedge mdc);
      #1;
      if (accept && !(cyc <= busy_until)) begin
         case (op)
            2'b00: m_ptr = data;
            2'b01: begin
               if (m_ptr == 16'd0) begin
                  if (data[15]) begin
                     m_defaults();
                     busy_until = cyc + RSTC;
                     m_lat = deskew;
                  end else m_reg[0] = {1'b0, data[14:0]};
               end else if (m_ptr != 16'd1 && m_ptr < 16'(NREG)) m_reg[m_ptr] = data;
            end
            2'b10: if (m_ptr != 16'hFFFF) m_ptr = m_ptr + 16'd1;
            default: ;
         endcase
      end
   endtask

   task automatic do_op(input logic [1:0] op, input logic [15:0] d);
      logic [15:0] g;
      frame(2'b01, op, PORT, DEV, d, 32, 1'b1, "R4", g);
   endtask

   task automatic do_rd(input logic [1:0] op, input logic [15:0] exp, input string tag);
      logic [15:0] g;
      frame(2'b01, op, PORT, DEV, 16'h0, 32, 1'b1, tag, g);
      chk(tag, g, exp);
   endtask

   task automatic set_deskew(input logic v);
      deskew = v;
      m_lat = m_lat & v;
      idle(4);
   endtask

   initial begin
      repeat (150000) @(posedge mdc);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R5: actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] g;
      m_defaults();
      m_lat = 1'b1;
      busy_until = 0;
      repeat (5) @(negedge mdc);
      chk("R12 oe during reset", {15'b0, dut_oe}, 16'h0);
      rst_n = 1'b1;
      busy_until = cyc + RSTC;

      // R12: reset period visible in bit 15 of address 0
      do_rd(2'b11, 16'h8000, "R12 busy after reset");
      idle(RSTC);
      do_rd(2'b11, 16'h0000, "R9 reset bit cleared");

      // R4 basic pointer / write / read
      do_op(2'b00, 16'd2);
      do_op(2'b01, 16'h1234);
      do_rd(2'b11, 16'h1234, "R4 write then read");

      // R8 defaults and out-of-range
      do_op(2'b00, 16'd3);
      do_rd(2'b11, 16'hA003, "R8 default addr 3");
      do_op(2'b00, 16'd7);
      do_rd(2'b11, 16'hA007, "R8 default addr 7");
      do_op(2'b00, 16'd8);
      do_op(2'b01, 16'h5555);
      do_rd(2'b11, 16'h0000, "R8 out of range reads 0");

      // R6 read then increment
      do_op(2'b00, 16'd4);
      do_rd(2'b10, 16'hA004, "R6 read-inc value");
      do_rd(2'b11, 16'hA005, "R6 pointer advanced");

      // R7 saturation at 0xFFFF
      do_op(2'b00, 16'd0);
      do_op(2'b01, 16'h0055);
      do_op(2'b00, 16'hFFFE);
      do_rd(2'b10, 16'h0000, "R7 read-inc at FFFE");
      do_rd(2'b10, 16'h0000, "R7 read-inc at FFFF");
      do_op(2'b01, 16'h7777);
      do_op(2'b00, 16'd0);
      do_rd(2'b11, 16'h0055, "R7 pointer did not wrap");

      // R3 identifier mismatch
      frame(2'b01, 2'b01, PORT ^ 5'h01, DEV, 16'h1111, 32, 1'b0, "R3 port mismatch", g);
      frame(2'b01, 2'b11, PORT, DEV ^ 5'h04, 16'h0000, 32, 1'b0, "R3 dev mismatch read", g);
      do_rd(2'b11, 16'h0055, "R3 state unchanged");

      // R2 bad start code
      frame(2'b00, 2'b01, PORT, DEV, 16'h2222, 32, 1'b0, "R2 start code 00", g);
      do_rd(2'b11, 16'h0055, "R2 bad start ignored");

      // R1 short preamble, directly after a frame
      frame(2'b01, 2'b01, PORT, DEV, 16'h3333, 31, 1'b0, "R1 31 ones", g);
      frame(2'b01, 2'b01, PORT, DEV, 16'h4444, 16, 1'b0, "R1 16 ones", g);
      do_rd(2'b11, 16'h0055, "R1 short preamble ignored");

      // R9 / R10 soft reset
      do_op(2'b00, 16'd2);
      do_op(2'b01, 16'hBEEF);
      do_op(2'b00, 16'd0);
      do_op(2'b01, 16'h8000);
      do_op(2'b01, 16'h4444);
      do_op(2'b00, 16'd3);
      do_rd(2'b11, 16'h8000, "R10 writes and load discarded while busy");
      idle(RSTC + 20);
      do_rd(2'b11, 16'h0000, "R9 reset bit self-cleared");
      do_op(2'b00, 16'd2);
      do_rd(2'b11, 16'hA002, "R9 default restored");

      // R11 latched-low de-skew status, R8 read-only address 1
      do_op(2'b00, 16'd1);
      do_rd(2'b11, 16'h0010, "R11 de-skewed");
      do_op(2'b01, 16'hFFFF);
      do_rd(2'b11, 16'h0010, "R8 address 1 read-only");
      set_deskew(1'b0);
      set_deskew(1'b1);
      do_rd(2'b11, 16'h0000, "R11 latched low");
      do_rd(2'b11, 16'h0010, "R11 released after read");
      set_deskew(1'b0);
      do_rd(2'b11, 16'h0000, "R11 live low");
      set_deskew(1'b1);
      do_rd(2'b11, 16'h0000, "R11 still latched");
      do_rd(2'b11, 16'h0010, "R11 follows input");

      idle(4);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule